// File: doc/BRIEF.md
# Radio Operating Mode Controller

This block turns a chip-level enable pin and a three-bit operating-mode code into the power-enable lines of a multi-channel radio. It drives the receive path, the receive low-noise amplifier, the transmit path, the LO generation path, the reference clock output, and the two calibration helpers: the AM detector and the receive I/Q buffers. When the pin is low, the whole radio is off. When the pin is high, the mode code chooses the set of blocks that are powered.

It also sequences four bias-enable lines for external power amplifiers. When the radio enters transmit, the amplifiers wait a programmable number of clock edges before they turn on. They turn off on the same edge that transmit ends, unless a hold flag keeps them on. Each amplifier line has its own mask bit. All of these lines are plain level controls, so the block has no streaming interface and no back-pressure.

Top module: `radio_mode_ctrl`

## Requirements
- R1: While en_pin is 0, every output is 0 one edge later, whatever the other inputs are (shutdown).
- R2: clk_out_on follows en_pin one edge later and ignores the mode code.
- R3: With en_pin at 1, mode 000 powers only the clock output. Mode 001 adds lo_on. Mode 010 adds rx_path_on, lna_on and lo_on. Mode 011 adds tx_path_on and lo_on.
- R4: Mode 100 (transmit calibration) sets tx_path_on, lo_on, amdet_on and rxbuf_on, and keeps rx_path_on and lna_on at 0.
- R5: Mode 101 (RF loopback) sets rx_path_on, tx_path_on and lo_on, and keeps lna_on, amdet_on and rxbuf_on at 0.
- R6: Modes 110 and 111 give the same outputs as standby (001).
- R7: In transmit (en_pin 1, mode 011) with delay D, pa_on rises exactly D edges after tx_path_on rises. With D = 0, both rise on the same edge.
- R8: The delay count restarts from zero each time transmit is entered, including after a stay that was shorter than D.
- R9: With pa_hold at 0, pa_on drops to 0 on the same edge that the radio leaves transmit.
- R10: With pa_hold at 1 and en_pin at 1, pa_on equals pa_mask in every mode other than transmit. In shutdown, pa_on is still 0.
- R11: Bit i of pa_on can be 1 only if bit i of pa_mask was 1 at the preceding edge.
- R12: All outputs are registered and are 0 during reset and at its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Chip enable pin; 0 gives shutdown |
| mode | input | 3 | Operating-mode code |
| pa_delay | input | DLY_W (4) | Edges from transmit entry to amplifier turn-on |
| pa_hold | input | 1 | Keep amplifier bias on outside transmit |
| pa_mask | input | N_PA (4) | Per-amplifier enable mask |
| rx_path_on | output | 1 | Receive path power |
| lna_on | output | 1 | Receive low-noise amplifier power |
| tx_path_on | output | 1 | Transmit path power |
| lo_on | output | 1 | LO generation power |
| clk_out_on | output | 1 | Reference clock output enable |
| amdet_on | output | 1 | AM detector power |
| rxbuf_on | output | 1 | Receive I/Q buffer power |
| pa_on | output | N_PA (4) | External amplifier bias enables |

## Verification
Every block enable, and the clock output, changes on the first edge after the inputs that cause it. The amplifier lines follow the same one-edge rule, except when they turn on in transmit: then they are due D edges after tx_path_on. The bench drives inputs on the falling edge. Its reference model updates on the rising edge from those inputs. Every output is compared with the model on the next falling edge, so each check samples the cycle the result is due. Test sequences cover short transmit stays, a delay change while counting, and a hold with the pin low, so that both timing limits are exercised.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

  typedef enum logic [2:0] {
    MD_CLKONLY = 3'b000,
    MD_STBY    = 3'b001,
    MD_RX      = 3'b010,
    MD_TX      = 3'b011,
    MD_TXCAL   = 3'b100,
    MD_LOOP    = 3'b101,
    MD_RSV6    = 3'b110,
    MD_RSV7    = 3'b111
  } mode_e;

  typedef struct packed {
    logic rx;
    logic lna;
    logic tx;
    logic lo;
    logic amdet;
    logic rxbuf;
  } blk_en_t;

  localparam blk_en_t BLK_OFF = '0;

endpackage

// File: rtl/rmc_decode.sv
module rmc_decode
  import rmc_pkg::*;
(
  input  logic       en_pin,
  input  logic [2:0] mode,
  output blk_en_t    blk,
  output logic       in_tx
);

  mode_e md;
  assign md = mode_e'(mode);

  always_comb begin
    blk   = BLK_OFF;
    in_tx = 1'b0;
    if (en_pin) begin
      unique case (md)
        MD_CLKONLY: blk = BLK_OFF;
        MD_RX: begin
          blk.rx  = 1'b1;
          blk.lna = 1'b1;
          blk.lo  = 1'b1;
        end
        MD_TX: begin
          blk.tx = 1'b1;
          blk.lo = 1'b1;
          in_tx  = 1'b1;
        end
        MD_TXCAL: begin
          blk.tx    = 1'b1;
          blk.lo    = 1'b1;
          blk.amdet = 1'b1;
          blk.rxbuf = 1'b1;
        end
        MD_LOOP: begin
          blk.rx = 1'b1;
          blk.tx = 1'b1;
          blk.lo = 1'b1;
        end
        default: blk.lo = 1'b1;  // standby and the two spare codes
      endcase
    end
  end

endmodule

// File: rtl/rmc_pa_seq.sv
module rmc_pa_seq #(
  parameter int N_PA  = 4,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_pin,
  input  logic             in_tx,
  input  logic [DLY_W-1:0] pa_delay,
  input  logic             pa_hold,
  input  logic [N_PA-1:0]  pa_mask,
  output logic [N_PA-1:0]  pa_on
);

  localparam logic [DLY_W-1:0] CNT_MAX = {DLY_W{1'b1}};

  logic [DLY_W-1:0] tx_cnt;
  logic             dly_done;
  logic             grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tx_cnt <= '0;
    else if (!in_tx)
      tx_cnt <= '0;
    else if (tx_cnt != CNT_MAX)
      tx_cnt <= tx_cnt + 1'b1;
  end

  assign dly_done = (tx_cnt >= pa_delay);
  assign grant    = in_tx ? dly_done : (en_pin & pa_hold);

  for (genvar g = 0; g < N_PA; g++) begin : g_pa
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pa_on[g] <= 1'b0;
      else
        pa_on[g] <= grant & pa_mask[g];
    end
  end

endmodule

// File: rtl/radio_mode_ctrl.sv
module radio_mode_ctrl
  import rmc_pkg::*;
#(
  parameter int N_PA  = 4,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_pin,
  input  logic [2:0]       mode,
  input  logic [DLY_W-1:0] pa_delay,
  input  logic             pa_hold,
  input  logic [N_PA-1:0]  pa_mask,
  output logic             rx_path_on,
  output logic             lna_on,
  output logic             tx_path_on,
  output logic             lo_on,
  output logic             clk_out_on,
  output logic             amdet_on,
  output logic             rxbuf_on,
  output logic [N_PA-1:0]  pa_on
);

  blk_en_t blk_nxt, blk_q;
  logic    in_tx;
  logic    clk_q;

  rmc_decode u_dec (
    .en_pin (en_pin),
    .mode   (mode),
    .blk    (blk_nxt),
    .in_tx  (in_tx)
  );

  rmc_pa_seq #(.N_PA(N_PA), .DLY_W(DLY_W)) u_pa (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_pin   (en_pin),
    .in_tx    (in_tx),
    .pa_delay (pa_delay),
    .pa_hold  (pa_hold),
    .pa_mask  (pa_mask),
    .pa_on    (pa_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= BLK_OFF;
      clk_q <= 1'b0;
    end else begin
      blk_q <= blk_nxt;
      clk_q <= en_pin;
    end
  end

  assign rx_path_on = blk_q.rx;
  assign lna_on     = blk_q.lna;
  assign tx_path_on = blk_q.tx;
  assign lo_on      = blk_q.lo;
  assign amdet_on   = blk_q.amdet;
  assign rxbuf_on   = blk_q.rxbuf;
  assign clk_out_on = clk_q;

endmodule

// File: rtl/radio_mode_ctrl_chk.sv
module radio_mode_ctrl_chk #(
  parameter int N_PA  = 4,
  parameter int DLY_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_pin,
  input logic [2:0]       mode,
  input logic [DLY_W-1:0] pa_delay,
  input logic             pa_hold,
  input logic [N_PA-1:0]  pa_mask,
  input logic             rx_path_on,
  input logic             lna_on,
  input logic             tx_path_on,
  input logic             lo_on,
  input logic             clk_out_on,
  input logic             amdet_on,
  input logic             rxbuf_on,
  input logic [N_PA-1:0]  pa_on
);

  logic tx_sel;
  assign tx_sel = en_pin && (mode == 3'b011);

  p_shutdown_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pin |=> (!rx_path_on && !lna_on && !tx_path_on && !lo_on &&
                 !clk_out_on && !amdet_on && !rxbuf_on && pa_on == '0));

  p_clkout_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_pin |=> clk_out_on);

  p_txcal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && mode == 3'b100) |=> (tx_path_on && lo_on && amdet_on &&
                                    rxbuf_on && !rx_path_on && !lna_on));

  p_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && mode == 3'b101) |=> (rx_path_on && tx_path_on && lo_on &&
                                    !lna_on && !amdet_on && !rxbuf_on));

  p_spare_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && mode[2:1] == 2'b11) |=> (lo_on && !rx_path_on && !tx_path_on &&
                                        !lna_on && !amdet_on && !rxbuf_on));

  p_entry_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel && !tx_path_on && pa_delay != '0) |=> (pa_on == '0));

  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && mode != 3'b011 && !pa_hold) |=> (pa_on == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_pin && mode != 3'b011 && pa_hold) |=> (pa_on == $past(pa_mask)));

  p_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) or 1'b1 |=> ((pa_on & ~$past(pa_mask)) == '0));

endmodule

bind radio_mode_ctrl radio_mode_ctrl_chk #(.N_PA(N_PA), .DLY_W(DLY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_pin     (en_pin),
  .mode       (mode),
  .pa_delay   (pa_delay),
  .pa_hold    (pa_hold),
  .pa_mask    (pa_mask),
  .rx_path_on (rx_path_on),
  .lna_on     (lna_on),
  .tx_path_on (tx_path_on),
  .lo_on      (lo_on),
  .clk_out_on (clk_out_on),
  .amdet_on   (amdet_on),
  .rxbuf_on   (rxbuf_on),
  .pa_on      (pa_on)
);

// File: tb/sim_radio_mode_ctrl.sv
module sim_radio_mode_ctrl;
  localparam int CLK_NS = 10;
  localparam int N_PA   = 4;
  localparam int DLY_W  = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en_pin = 1'b0;
  logic [2:0]       mode = 3'b000;
  logic [DLY_W-1:0] pa_delay = '0;
  logic             pa_hold = 1'b0;
  logic [N_PA-1:0]  pa_mask = '0;
  logic rx_path_on, lna_on, tx_path_on, lo_on, clk_out_on, amdet_on, rxbuf_on;
  logic [N_PA-1:0]  pa_on;

  radio_mode_ctrl #(.N_PA(N_PA), .DLY_W(DLY_W)) u0 (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .mode(mode),
    .pa_delay(pa_delay), .pa_hold(pa_hold), .pa_mask(pa_mask),
    .rx_path_on(rx_path_on), .lna_on(lna_on), .tx_path_on(tx_path_on),
    .lo_on(lo_on), .clk_out_on(clk_out_on), .amdet_on(amdet_on),
    .rxbuf_on(rxbuf_on), .pa_on(pa_on)
  );

  always #(CLK_NS/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural reference: {rx, lna, tx, lo, amdet, rxbuf}
  logic [5:0]      e_blk = '0;
  logic            e_clk = 1'b0;
  logic [N_PA-1:0] e_pa = '0;
  int              tx_run = 0;
  string           blk_tag = "R12";
  string           pa_tag = "R12";

  always @(posedge clk) begin
    if (!rst_n) begin
      e_blk = '0; e_clk = 0; e_pa = '0; tx_run = 0;
      blk_tag = "R12"; pa_tag = "R12";
    end else begin
      e_clk = en_pin;
      if (!en_pin) begin
        e_blk = '0; blk_tag = "R1";
      end else begin
        case (mode)
          3'd0: begin e_blk = 6'b000000; blk_tag = "R3"; end
          3'd1: begin e_blk = 6'b000100; blk_tag = "R3"; end
          3'd2: begin e_blk = 6'b110100; blk_tag = "R3"; end
          3'd3: begin e_blk = 6'b001100; blk_tag = "R3"; end
          3'd4: begin e_blk = 6'b001111; blk_tag = "R4"; end
          3'd5: begin e_blk = 6'b101100; blk_tag = "R5"; end
          default: begin e_blk = 6'b000100; blk_tag = "R6"; end
        endcase
      end
      if (en_pin && mode == 3'd3) begin
        e_pa = (tx_run >= int'(pa_delay)) ? pa_mask : '0;
        pa_tag = "R7/R8/R11";
        tx_run = tx_run + 1;
      end else begin
        e_pa = (en_pin && pa_hold) ? pa_mask : '0;
        pa_tag = !en_pin ? "R1" : (pa_hold ? "R10/R11" : "R9");
        tx_run = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R2 clk_out", {7'd0, clk_out_on}, {7'd0, e_clk});
      chk({blk_tag, " enables"},
          {2'b00, rx_path_on, lna_on, tx_path_on, lo_on, amdet_on, rxbuf_on},
          {2'b00, e_blk});
      chk({pa_tag, " pa_on"}, {4'd0, pa_on}, {4'd0, e_pa});
    end
  end

  task automatic drive(input logic e, input logic [2:0] m, input int d,
                       input logic h, input logic [3:0] k, input int n);
    @(negedge clk);
    en_pin = e; mode = m; pa_delay = DLY_W'(d); pa_hold = h; pa_mask = k;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R12: reset state, with busy inputs held
    en_pin = 1; mode = 3'd4; pa_hold = 1; pa_mask = 4'hF;
    repeat (3) @(negedge clk);
    @(negedge clk); rst_n = 1;
    // R3 R4 R5 R6: sweep every code with pin high
    for (int m = 0; m < 8; m++) drive(1, 3'(m), 2, 0, 4'hF, 3);
    // R1: pin low over every code, hold set
    for (int m = 0; m < 8; m++) drive(0, 3'(m), 0, 1, 4'hF, 2);
    // R7: delay 5, full mask, then leave (R9)
    drive(1, 3'd1, 5, 0, 4'hF, 3);
    drive(1, 3'd3, 5, 0, 4'hF, 10);
    drive(1, 3'd1, 5, 0, 4'hF, 3);
    // R8: short stay then re-entry restarts count
    drive(1, 3'd3, 6, 0, 4'hA, 3);
    drive(1, 3'd2, 6, 0, 4'hA, 1);
    drive(1, 3'd3, 6, 0, 4'hA, 9);
    // R7: zero delay, R11 masks
    drive(1, 3'd1, 0, 0, 4'h5, 2);
    drive(1, 3'd3, 0, 0, 4'h5, 4);
    drive(1, 3'd3, 0, 0, 4'h8, 3);
    // R10: hold across calibration, loopback, then shutdown
    drive(1, 3'd4, 0, 1, 4'h6, 3);
    drive(1, 3'd5, 0, 1, 4'h6, 2);
    drive(0, 3'd3, 0, 1, 4'h6, 3);
    // R7: max delay, change mid-count
    drive(1, 3'd3, 15, 0, 4'hF, 8);
    drive(1, 3'd3, 3, 0, 4'h3, 4);
    drive(1, 3'd3, 15, 0, 4'hF, 20);
    // R9: leave transmit straight into shutdown, hold clear
    drive(0, 3'd3, 15, 0, 4'hF, 3);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule